// File: doc/BRIEF.md
# LED PWM Channel Combiner

This block turns a small set of brightness settings into the drive waveforms of four LED pins. Each channel has an 8-bit duty value and a 2-bit state code. One shared group signal, set by a group duty value and a group rate value, either dims all selected channels at a fixed rate or blinks them with a programmable period. A channel that selects the group has its own PWM ANDed with the group signal. The logical result may be inverted. It is then mapped to a low-drive, high-drive or high-impedance enable, for totem-pole or open-drain pins.

All timing comes from a tick enable that is nominally 400 kHz. Settings arrive on parallel inputs and are captured when the update strobe is high. The captured values become active only at the end of the current 256-tick PWM period, so a change never leaves a runt pulse. A sleep input freezes every counter and therefore every pin.

Top module: `led_pwm_combiner`

## Requirements
- R1: After reset, all duty values are 00h, group duty is FFh, group rate is 00h, dimming mode is selected, inversion is off, the pins are open-drain and every state code is 00. Each pin therefore reports high-Z.
- R2: State code 00 keeps the LED off at all times. Code 01 keeps it on at all times, whatever the duty value.
- R3: With state code 10, the LED is on for exactly `duty` ticks out of every 256.
- R4: With state code 11 in dimming mode (blink bit 0), the channel PWM repeats every 64 ticks and is on for duty[7:2] of them. The group gate has 16 slots of 128 ticks and is open in the first group_duty[7:4] slots. Over any 2048 ticks the LED is on for group_duty[7:4]·2·duty[7:2] ticks, and the group rate value has no effect. A code 10 channel keeps its 256-step PWM in this mode.
- R5: In blink mode (blink bit 1), the group period is 256·(rate+1)·BLINK_PRE ticks, split into 256 equal slots. A code 11 channel uses its full 8-bit, 256-tick PWM ANDed with a gate that is open in the first slots of that period.
- R6: In blink mode the number of open slots is group_duty with the two low bits cleared when rate ≤ 3 (24 Hz to 6 Hz), and the full group_duty when rate ≥ 4.
- R7: The pin level is NOT(led XOR invert). At a high level, totem-pole mode asserts drive-high and open-drain mode asserts high-Z. At a low level, both modes assert drive-low. Exactly one of the three enables is active per pin.
- R8: Values captured on the update strobe take effect only at the tick that ends a 256-tick PWM period. Until then the outputs follow the previous settings.
- R9: While sleep is high or the tick is low, no counter advances, so every pin enable stays constant.
- R10: A duty of 0 under code 10 or 11, or duty[7:2] = 0 under code 11 in dimming mode, keeps the LED off on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 400 kHz timing enable |
| sleep | input | 1 | Freezes all PWM activity |
| upd | input | 1 | Captures the setting inputs |
| duty_in | input | 32 | Per-channel duty, channel n in bits [8n+7:8n] |
| code_in | input | 8 | Per-channel state code, channel n in bits [2n+1:2n] |
| gdc_in | input | 8 | Group duty |
| gfrq_in | input | 8 | Group rate (blink period) |
| blink_in | input | 1 | 0 = group dimming, 1 = group blinking |
| invert_in | input | 1 | Inverts the logical output |
| totem_in | input | 1 | 1 = totem-pole, 0 = open-drain |
| drv_lo | output | 4 | Per-pin drive-low enable |
| drv_hi | output | 4 | Per-pin drive-high enable |
| hi_z | output | 4 | Per-pin high-impedance enable |

## Verification
The hardest case is the blink gate combined with the channel PWM. The phase between the blink period and the 256-tick PWM period depends on the whole history of the group rate, so a cycle-exact pin model would have to copy the design. The bench instead counts on-ticks over exactly one blink period, which makes the count independent of phase. It chooses rate and group-duty pairs whose open span is a whole number of 256-tick periods, so the expected count is a plain product. The pairs are also chosen so that the 64-step and 256-step duty readings give different counts. To test the deferred update, the bench first finds the period boundary from the port side: a duty-1 channel is on only at counter zero. It then strobes a change just after that boundary.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int CH_N         = 4;
    localparam int DUTY_W       = 8;
    localparam int FINE_DROP    = 2;
    localparam int DIM_SLOTS    = 16;
    localparam int DIM_SLOT_LEN = 128;
    localparam int FAST_MAX     = 3;
    localparam int SLOT_W       = $clog2(DIM_SLOTS);
    localparam int CODE_W       = 2;

    typedef enum logic [1:0] {
        LS_OFF = 2'b00,
        LS_ON  = 2'b01,
        LS_IND = 2'b10,
        LS_GRP = 2'b11
    } lstate_e;

    typedef struct packed {
        logic [CH_N-1:0][DUTY_W-1:0] duty;
        logic [CH_N-1:0][CODE_W-1:0] code;
        logic [DUTY_W-1:0]           gdc;
        logic [DUTY_W-1:0]           gfrq;
        logic                        blink;
        logic                        inv;
        logic                        totem;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        duty:  '0,
        code:  '0,
        gdc:   8'hFF,
        gfrq:  8'h00,
        blink: 1'b0,
        inv:   1'b0,
        totem: 1'b0
    };

    // Number of open blink slots: coarse steps for fast rates, full steps otherwise.
    function automatic logic [DUTY_W-1:0] blink_open(input logic [DUTY_W-1:0] gdc,
                                                     input logic [DUTY_W-1:0] gfrq);
        if (gfrq <= DUTY_W'(FAST_MAX))
            return {gdc[DUTY_W-1:FINE_DROP], {FINE_DROP{1'b0}}};
        return gdc;
    endfunction

endpackage

// File: rtl/lpc_regs.sv
module lpc_regs
    import lpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic period_end,
    input  cfg_t raw,
    output cfg_t act
);

    cfg_t stage;
    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= CFG_RST;
            act   <= CFG_RST;
            pend  <= 1'b0;
        end else begin
            if (upd)
                stage <= raw;
            if (period_end && pend)
                act <= stage;
            if (upd)
                pend <= 1'b1;
            else if (period_end)
                pend <= 1'b0;
        end
    end

    // R8: active settings move only at a period boundary
    a_r8_steady: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(act));

    // R8: a pending capture lands at the boundary
    a_r8_take: assert property (@(posedge clk) disable iff (rst)
        (period_end && pend) |=> act == $past(stage));

endmodule

// File: rtl/lpc_timebase.sv
module lpc_timebase
    import lpc_pkg::*;
#(
    parameter int BLINK_PRE = 65
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [DUTY_W-1:0] gfrq,
    output logic [DUTY_W-1:0] ind_cnt,
    output logic [SLOT_W-1:0] dim_slot,
    output logic [DUTY_W-1:0] blink_slot,
    output logic              period_end
);

    localparam int TW = $clog2(DIM_SLOTS * DIM_SLOT_LEN);
    localparam int PW = (BLINK_PRE > 1) ? $clog2(BLINK_PRE) : 1;

    logic [TW-1:0]     tcnt;
    logic [PW-1:0]     pre;
    logic [DUTY_W-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt       <= '0;
            pre        <= '0;
            sub        <= '0;
            blink_slot <= '0;
        end else if (adv) begin
            tcnt <= tcnt + 1'b1;
            if (pre == PW'(BLINK_PRE - 1)) begin
                pre <= '0;
                if (sub >= gfrq) begin
                    sub        <= '0;
                    blink_slot <= blink_slot + 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    assign ind_cnt    = tcnt[DUTY_W-1:0];
    assign dim_slot   = tcnt[TW-1 -: SLOT_W];
    assign period_end = adv && (ind_cnt == '1);

    // R9: no time passes without an enabled tick
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(tcnt) && $stable(blink_slot) && $stable(sub));

endmodule

// File: rtl/lpc_chan.sv
module lpc_chan
    import lpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] ind_cnt,
    input  logic              grp_on,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CODE_W-1:0] code,
    input  logic              blink,
    input  logic              inv,
    input  logic              totem,
    output logic              drv_lo,
    output logic              drv_hi,
    output logic              hi_z
);

    localparam int CW = DUTY_W - FINE_DROP;

    lstate_e st;
    logic    ind_on;
    logic    led_on;
    logic    level;

    assign st = lstate_e'(code);

    always_comb begin
        if (st == LS_GRP && !blink)
            ind_on = ind_cnt[CW-1:0] < duty[DUTY_W-1:FINE_DROP];
        else
            ind_on = ind_cnt < duty;
        unique case (st)
            LS_OFF:  led_on = 1'b0;
            LS_ON:   led_on = 1'b1;
            LS_IND:  led_on = ind_on;
            default: led_on = ind_on && grp_on;
        endcase
    end

    assign level  = ~(led_on ^ inv);
    assign drv_lo = ~level;
    assign drv_hi = level & totem;
    assign hi_z   = level & ~totem;

    // R7: exactly one pin enable
    a_r7_one_enable: assert property (@(posedge clk) disable iff (rst)
        $countones({drv_lo, drv_hi, hi_z}) == 1);

    // R2: code 01 is steadily on
    a_r2_full_on: assert property (@(posedge clk) disable iff (rst)
        (st == LS_ON) |-> (drv_lo == !inv));

    // R10: zero duty never lights the LED
    a_r10_zero_duty: assert property (@(posedge clk) disable iff (rst)
        (code[1] && duty == '0) |-> (drv_lo == inv));

endmodule

// File: rtl/led_pwm_combiner.sv
module led_pwm_combiner
    import lpc_pkg::*;
#(
    parameter int BLINK_PRE = 65
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick,
    input  logic                     sleep,
    input  logic                     upd,
    input  logic [CH_N*DUTY_W-1:0]   duty_in,
    input  logic [CH_N*CODE_W-1:0]   code_in,
    input  logic [DUTY_W-1:0]        gdc_in,
    input  logic [DUTY_W-1:0]        gfrq_in,
    input  logic                     blink_in,
    input  logic                     invert_in,
    input  logic                     totem_in,
    output logic [CH_N-1:0]          drv_lo,
    output logic [CH_N-1:0]          drv_hi,
    output logic [CH_N-1:0]          hi_z
);

    cfg_t              raw;
    cfg_t              act;
    logic              adv;
    logic              period_end;
    logic [DUTY_W-1:0] ind_cnt;
    logic [SLOT_W-1:0] dim_slot;
    logic [DUTY_W-1:0] blink_slot;
    logic              grp_on;

    always_comb begin
        raw.duty  = duty_in;
        raw.code  = code_in;
        raw.gdc   = gdc_in;
        raw.gfrq  = gfrq_in;
        raw.blink = blink_in;
        raw.inv   = invert_in;
        raw.totem = totem_in;
    end

    assign adv = tick && !sleep;

    lpc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd),
        .period_end (period_end),
        .raw        (raw),
        .act        (act)
    );

    lpc_timebase #(.BLINK_PRE(BLINK_PRE)) u_time (
        .clk        (clk),
        .rst        (rst),
        .adv        (adv),
        .gfrq       (act.gfrq),
        .ind_cnt    (ind_cnt),
        .dim_slot   (dim_slot),
        .blink_slot (blink_slot),
        .period_end (period_end)
    );

    always_comb begin
        if (act.blink)
            grp_on = blink_slot < blink_open(act.gdc, act.gfrq);
        else
            grp_on = dim_slot < act.gdc[DUTY_W-1 -: SLOT_W];
    end

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        lpc_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .ind_cnt (ind_cnt),
            .grp_on  (grp_on),
            .duty    (act.duty[c]),
            .code    (act.code[c]),
            .blink   (act.blink),
            .inv     (act.inv),
            .totem   (act.totem),
            .drv_lo  (drv_lo[c]),
            .drv_hi  (drv_hi[c]),
            .hi_z    (hi_z[c])
        );
    end

    // R9: sleep holds every pin
    a_r9_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(sleep) && sleep && !$past(upd)) |-> $stable({drv_lo, drv_hi, hi_z}));

endmodule

// File: tb/tb_led_pwm_combiner.sv
module tb_led_pwm_combiner;

    localparam int PRE = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        sleep = 1'b0;
    logic        upd = 1'b0;
    logic [31:0] duty_in = '0;
    logic [7:0]  code_in = '0;
    logic [7:0]  gdc_in = '0;
    logic [7:0]  gfrq_in = '0;
    logic        blink_in = 1'b0;
    logic        invert_in = 1'b0;
    logic        totem_in = 1'b0;
    logic [3:0]  drv_lo;
    logic [3:0]  drv_hi;
    logic [3:0]  hi_z;

    int n_chk = 0;
    int n_bad = 0;
    int acc [4];

    led_pwm_combiner #(.BLINK_PRE(PRE)) dut (
        .clk(clk), .rst(rst), .tick(tick), .sleep(sleep), .upd(upd),
        .duty_in(duty_in), .code_in(code_in), .gdc_in(gdc_in), .gfrq_in(gfrq_in),
        .blink_in(blink_in), .invert_in(invert_in), .totem_in(totem_in),
        .drv_lo(drv_lo), .drv_hi(drv_hi), .hi_z(hi_z)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply();
        @(negedge clk);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    task automatic measure(input int n);
        for (int i = 0; i < 4; i++) acc[i] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) if (drv_lo[i]) acc[i]++;
        end
    endtask

    function automatic int pins(input int ch);
        return {29'd0, drv_lo[ch], drv_hi[ch], hi_z[ch]};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int d;
        int snap;
        int moved;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state, every pin high-Z
        chk("R1 hi_z", int'(hi_z), 15);
        chk("R1 drv_lo", int'(drv_lo), 0);

        // R2 / R10: off, on, zero duty, max duty
        code_in = {2'b10, 2'b10, 2'b01, 2'b00};
        duty_in = {8'hFF, 8'h00, 8'h80, 8'h80};
        apply();
        measure(256);
        chk("R2 code 00 off", acc[0], 0);
        chk("R2 code 01 on", acc[1], 256);
        chk("R10 duty zero", acc[2], 0);
        chk("R3 duty FF", acc[3], 255);

        // R3: individual sweep
        code_in = 8'hAA;
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < 4; i++) duty_in[i*8 +: 8] = 8'((k * 37 + i * 61) % 256);
            apply();
            measure(256);
            for (int i = 0; i < 4; i++) chk("R3 individual", acc[i], (k * 37 + i * 61) % 256);
        end

        // R4: group dimming sweep, ch3 stays individual
        code_in  = {2'b10, 2'b11, 2'b11, 2'b11};
        duty_in  = {8'h41, 8'h40, 8'hFF, 8'h03};
        gfrq_in  = 8'h55;
        blink_in = 1'b0;
        for (int g = 0; g < 16; g++) begin
            gdc_in = {4'(g), 4'hA};
            apply();
            measure(2048);
            chk("R10 dim coarse zero", acc[0], 0);
            chk("R4 dim ch1", acc[1], g * 2 * 63);
            chk("R4 dim ch2", acc[2], g * 2 * 16);
            chk("R4 code10 in dim", acc[3], 8 * 65);
        end

        // R5 / R6: blink windows of exactly one period
        code_in  = {2'b01, 2'b11, 2'b11, 2'b11};
        duty_in  = {8'h10, 8'h00, 8'h80, 8'hFF};
        blink_in = 1'b1;
        for (int c = 0; c < 4; c++) begin
            int per;
            int mult;
            case (c)
                0: begin gfrq_in = 8'd3;  gdc_in = 8'h43; mult = 2;  end
                1: begin gfrq_in = 8'd1;  gdc_in = 8'h81; mult = 2;  end
                2: begin gfrq_in = 8'd63; gdc_in = 8'h42; mult = 33; end
                default: begin gfrq_in = 8'd7; gdc_in = 8'h40; mult = 4; end
            endcase
            per = 256 * (int'(gfrq_in) + 1) * PRE;
            apply();
            measure(per);
            chk("R5 blink ch0", acc[0], mult * 255);
            chk("R6 blink ch1", acc[1], mult * 128);
            chk("R10 blink zero", acc[2], 0);
            chk("R5 blink period", acc[3], per);
        end

        // R7: inversion and drive structure
        blink_in = 1'b0;
        code_in  = {2'b00, 2'b00, 2'b01, 2'b00};
        for (int m = 0; m < 4; m++) begin
            invert_in = m[0];
            totem_in  = m[1];
            apply();
            // ch0 led off: level = ~inv; ch1 led on: level = inv
            chk("R7 off pin", pins(0), (!m[0]) ? (m[1] ? 2 : 1) : 4);
            chk("R7 on pin",  pins(1), ( m[0]) ? (m[1] ? 2 : 1) : 4);
        end
        invert_in = 1'b0;
        totem_in  = 1'b0;

        // R8: change deferred to period end
        code_in = {2'b00, 2'b00, 2'b00, 2'b10};
        duty_in = {8'h00, 8'h00, 8'h00, 8'h01};
        apply();
        d = 0;
        while (!drv_lo[0] && d < 300) begin
            @(negedge clk);
            d++;
        end
        code_in = {2'b00, 2'b00, 2'b01, 2'b10};
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        repeat (199) @(negedge clk);
        chk("R8 before boundary", int'(hi_z[1]), 1);
        repeat (100) @(negedge clk);
        chk("R8 after boundary", int'(drv_lo[1]), 1);

        // R9: sleep and missing tick freeze pins
        code_in = {2'b00, 2'b00, 2'b00, 2'b10};
        duty_in = {8'h00, 8'h00, 8'h00, 8'h80};
        apply();
        sleep = 1'b1;
        @(negedge clk);
        snap  = int'({drv_lo, drv_hi, hi_z});
        moved = 0;
        repeat (600) begin
            @(negedge clk);
            if (int'({drv_lo, drv_hi, hi_z}) != snap) moved++;
        end
        chk("R9 sleep frozen", moved, 0);
        sleep = 1'b0;
        measure(256);
        chk("R9 resumes", acc[0], 128);
        tick = 1'b0;
        @(negedge clk);
        snap  = int'({drv_lo, drv_hi, hi_z});
        moved = 0;
        repeat (300) begin
            @(negedge clk);
            if (int'({drv_lo, drv_hi, hi_z}) != snap) moved++;
        end
        chk("R9 tick frozen", moved, 0);
        tick = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule